// File: doc/BRIEF.md
# Oscillator calibration window counter

This block measures a slow reference oscillator against the fast system clock. Software picks one of four reference inputs and loads a window length, given in reference periods. It then sets a start bit. The block waits for the first rising edge of the chosen reference. From that edge on, it counts fast clock cycles until the programmed number of further reference edges has passed. It then drops the start bit, which serves as the busy flag. The 32-bit count can then be read as two half-words. Dividing the count by the window length gives the reference period in fast cycles, which calibration firmware uses to trim the oscillator.

All reference inputs and the external gate input are treated as asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector in the fast clock domain. An alternative gating mode counts fast cycles only while the synchronized external input is high. In that mode the window length is still set by the reference edges.

Top module: `osc_cal_counter`

## Requirements
- R1: After reset, all four registers read as zero and no calibration is in progress.
- R2: The control register is at byte offset 0x0. Reference select is in bits [1:0], start/busy in bit 2 and gating-source select in bit 3. Bits [15:4] always read zero.
- R3: Writing 1 to bit 2 while idle starts a calibration. Bit 2 then reads 1 until the measurement ends, and hardware clears it by itself.
- R4: The window-length register is at offset 0x2. It is 16 bits wide and reads back the last value accepted.
- R5: In reference gating mode (bit 3 = 0), the result equals the window length times the reference period in fast cycles. Counting runs from the first reference edge after start up to and including the edge that ends the window.
- R6: Select values 0, 1, 2 and 3 measure reference inputs ref_clk_in[0], [1], [2] and [3] respectively.
- R7: The result is cleared to zero in the cycle after a calibration starts.
- R8: A window length of 0 gives the same measurement as a window length of 1.
- R9: In external gating mode (bit 3 = 1), fast cycles inside the window count only while the synchronized ext_gate_in is high. The window still ends on reference edges.
- R10: While a calibration is busy, writes to the control register (select, source and start) and to the window register are ignored.
- R11: The 32-bit result reads at offset 0x4 (bits [15:0]) and offset 0x6 (bits [31:16]). Writes to these offsets have no effect.
- R12: Read data is registered. bus_rdata shows the register addressed by bus_addr[2:1] one clock after the address is presented. bus_addr[0] is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ref_clk_in | input | 4 | Asynchronous reference oscillator inputs |
| ext_gate_in | input | 1 | Asynchronous external counting gate |

## Verification
The four reference inputs toggle with different periods, so a wrong select or an off-by-one in the window shows up as a wrong multiple of the expected period. A long window pushes the count past 16 bits, which checks that the high half-word carries correctly. External gating is tried with the gate held low (the result must be zero), held high (the result must equal reference mode) and toggling in an irregular pattern (checked cycle by cycle against the model). Writes made during a busy window, window length 0 and reads taken just after start tell apart the ignore, clamp and clear rules.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned RES_W     = 32;
  localparam int unsigned BIT_START = 2;
  localparam int unsigned BIT_SRC   = 3;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_WIN  = 2'd1;
  localparam logic [1:0] IDX_RLO  = 2'd2;
  localparam logic [1:0] IDX_RHI  = 2'd3;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_ARM  = 2'd1,
    CAL_RUN  = 2'd2
  } cal_state_e;
endpackage

// File: rtl/osc_cal_sync.sv
module osc_cal_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [WIDTH-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_edge
      assign level[g] = pipe[STAGES-1][g];
      assign rise[g]  = pipe[STAGES-1][g] & ~pipe[STAGES][g];
    end
  endgenerate
endmodule

// File: rtl/osc_cal_engine.sv
module osc_cal_engine
  import osc_cal_pkg::*;
#(
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_REF = 4,
  parameter int unsigned SEL_W   = $clog2(NUM_REF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_req,
  input  logic [SEL_W-1:0]   sel,
  input  logic               ext_mode,
  input  logic [WIN_W-1:0]   win_len,
  input  logic [NUM_REF-1:0] ref_rise,
  input  logic               ext_level,
  output logic               busy,
  output logic [CNT_W-1:0]   count,
  output cal_state_e         state_o
);
  localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

  cal_state_e       state;
  logic [WIN_W-1:0] remain;
  logic             edge_hit;
  logic             gate;

  assign edge_hit = ref_rise[sel];
  assign gate     = ext_mode ? ext_level : 1'b1;
  assign state_o  = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CAL_IDLE;
      busy   <= 1'b0;
      count  <= '0;
      remain <= '0;
    end else begin
      unique case (state)
        CAL_IDLE: begin
          if (start_req) begin
            state  <= CAL_ARM;
            busy   <= 1'b1;
            count  <= '0;
            remain <= (win_len == '0) ? ONE : win_len;
          end
        end
        CAL_ARM: begin
          if (edge_hit) state <= CAL_RUN;
        end
        CAL_RUN: begin
          if (gate) count <= count + CNT_W'(1);
          if (edge_hit) begin
            if (remain == ONE) begin
              state <= CAL_IDLE;
              busy  <= 1'b0;
            end else begin
              remain <= remain - ONE;
            end
          end
        end
        default: state <= CAL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/osc_cal_regs.sv
module osc_cal_regs
  import osc_cal_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic              src_q,
  output logic [DATA_W-1:0] win_q,
  output logic              start_req
);
  logic [1:0]        idx;
  logic              ctrl_wr;
  logic              win_wr;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] rd_next;

  assign idx       = bus_addr[2:1];
  assign ctrl_wr   = bus_wr && (idx == IDX_CTRL) && !busy;
  assign win_wr    = bus_wr && (idx == IDX_WIN) && !busy;
  assign start_req = ctrl_wr && bus_wdata[BIT_START];

  always_comb begin
    ctrl_view                 = '0;
    ctrl_view[SEL_W-1:0]      = sel_q;
    ctrl_view[BIT_START]      = busy;
    ctrl_view[BIT_SRC]        = src_q;
  end

  always_comb begin
    unique case (idx)
      IDX_CTRL: rd_next = ctrl_view;
      IDX_WIN:  rd_next = win_q;
      IDX_RLO:  rd_next = count[DATA_W-1:0];
      default:  rd_next = count[CNT_W-1:CNT_W-DATA_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      src_q     <= 1'b0;
      win_q     <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_next;
      if (ctrl_wr) begin
        sel_q <= bus_wdata[SEL_W-1:0];
        src_q <= bus_wdata[BIT_SRC];
      end
      if (win_wr) win_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/osc_cal_counter.sv
module osc_cal_counter
  import osc_cal_pkg::*;
#(
  parameter int unsigned NUM_REF     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [NUM_REF-1:0] ref_clk_in,
  input  logic               ext_gate_in
);
  localparam int unsigned SEL_W  = $clog2(NUM_REF);
  localparam int unsigned SYNC_W = NUM_REF + 1;

  logic [SYNC_W-1:0]  sync_level;
  logic [SYNC_W-1:0]  sync_rise;
  logic [SEL_W-1:0]   sel_q;
  logic               src_q;
  logic [REG_W-1:0]   win_q;
  logic               start_req;
  logic               busy;
  logic [RES_W-1:0]   count;
  cal_state_e         state;

  osc_cal_sync #(
    .WIDTH (SYNC_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({ext_gate_in, ref_clk_in}),
    .level(sync_level),
    .rise (sync_rise)
  );

  osc_cal_regs #(
    .DATA_W(REG_W),
    .CNT_W (RES_W),
    .SEL_W (SEL_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .busy     (busy),
    .count    (count),
    .bus_rdata(bus_rdata),
    .sel_q    (sel_q),
    .src_q    (src_q),
    .win_q    (win_q),
    .start_req(start_req)
  );

  osc_cal_engine #(
    .WIN_W  (REG_W),
    .CNT_W  (RES_W),
    .NUM_REF(NUM_REF),
    .SEL_W  (SEL_W)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start_req(start_req),
    .sel      (sel_q),
    .ext_mode (src_q),
    .win_len  (win_q),
    .ref_rise (sync_rise[NUM_REF-1:0]),
    .ext_level(sync_level[NUM_REF]),
    .busy     (busy),
    .count    (count),
    .state_o  (state)
  );
endmodule

// File: rtl/osc_cal_chk.sv
module osc_cal_chk #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_req,
  input logic             busy,
  input logic [SEL_W-1:0] sel_q,
  input logic             src_q,
  input logic [WIN_W-1:0] win_q,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       bus_addr,
  input logic [WIN_W-1:0] bus_rdata
);
  p_busy_set_r3: assert property (@(posedge clk) disable iff (rst)
    start_req |=> busy);

  p_clear_at_start_r7: assert property (@(posedge clk) disable iff (rst)
    start_req |=> (count == '0));

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(sel_q) && $stable(src_q) && $stable(win_q)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_req) |=> $stable(count));

  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start_req);

  p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[2:1] == 2'd0) |=> (bus_rdata[WIN_W-1:4] == '0));
endmodule

bind osc_cal_counter osc_cal_chk #(
  .SEL_W(SEL_W),
  .WIN_W(osc_cal_pkg::REG_W),
  .CNT_W(osc_cal_pkg::RES_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_req(start_req),
  .busy     (busy),
  .sel_q    (sel_q),
  .src_q    (src_q),
  .win_q    (win_q),
  .count    (count),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/osc_cal_counter_tb.sv
module osc_cal_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [3:0]  ref_clk_in = 4'd0;
  logic        ext_gate_in = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ext_pat = 0;     // 0 low, 1 high, 2 toggling
  bit seen_edge = 1'b0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  osc_cal_counter dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_clk_in(ref_clk_in), .ext_gate_in(ext_gate_in)
  );

  // reference generators: half periods in fast cycles
  int half [4] = '{20, 3, 25, 11};
  int tcnt [4] = '{0, 0, 0, 0};
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 4; i++) begin
      if (tcnt[i] + 1 >= half[i]) begin
        tcnt[i] <= 0;
        ref_clk_in[i] <= ~ref_clk_in[i];
      end else tcnt[i] <= tcnt[i] + 1;
    end
    case (ext_pat)
      0: ext_gate_in <= 1'b0;
      1: ext_gate_in <= 1'b1;
      default: ext_gate_in <= ((cyc % 7) < 3) ^ ((cyc % 13) == 5);
    endcase
  end

  // behavioural reference model
  logic [4:0] h1 = 0, h2 = 0, h3 = 0;
  int m_state = 0;
  bit m_busy = 0, m_src = 0;
  int m_sel = 0;
  int unsigned m_win = 0, m_dn = 0, m_res = 0;
  logic [15:0] exp_rd = 0;
  logic [1:0]  exp_idx = 0;

  always @(posedge clk) begin
    if (rst) begin
      h1 = 0; h2 = 0; h3 = 0; m_state = 0; m_busy = 0; m_src = 0;
      m_sel = 0; m_win = 0; m_dn = 0; m_res = 0; exp_rd = 0;
    end else begin
      bit r, e, b_old;
      r = h2[m_sel] & ~h3[m_sel];
      e = h2[4];
      b_old = m_busy;
      exp_idx = bus_addr[2:1];
      case (bus_addr[2:1])
        2'd0: exp_rd = {12'd0, m_src, m_busy, 2'(m_sel)};
        2'd1: exp_rd = 16'(m_win);
        2'd2: exp_rd = m_res[15:0];
        default: exp_rd = m_res[31:16];
      endcase
      if (m_state == 2) begin
        if (!m_src || e) m_res = m_res + 1;
        if (r) begin
          if (m_dn == 1) begin m_state = 0; m_busy = 0; end
          else m_dn = m_dn - 1;
        end
      end else if (m_state == 1) begin
        if (r) m_state = 2;
      end
      if (bus_wr && !b_old) begin
        if (bus_addr[2:1] == 2'd0) begin
          m_sel = int'(bus_wdata[1:0]);
          m_src = bus_wdata[3];
          if (bus_wdata[2]) begin
            m_busy = 1; m_state = 1; m_res = 0;
            m_dn = (m_win == 0) ? 1 : m_win;
          end
        end else if (bus_addr[2:1] == 2'd1) m_win = bus_wdata;
      end
      h3 = h2; h2 = h1; h1 = {ext_gate_in, ref_clk_in};
      seen_edge = 1'b1;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (seen_edge && !rst && !done_flag) begin
      total++;
      if (bus_rdata !== exp_rd) begin
        bad++;
        $display("FAIL R12 model compare idx=%0d actual=%h expected=%h",
                 exp_idx, bus_rdata, exp_rd);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] v;
    int n = 0;
    do begin
      rd_reg(3'd0, v);
      n++;
    end while (v[2] && n < 60000);
    check(!v[2], tag, int'(v[2]), 0);
  endtask

  task automatic read_res(output int unsigned r);
    logic [15:0] lo, hi;
    rd_reg(3'd4, lo);
    rd_reg(3'd6, hi);
    r = {hi, lo};
  endtask

  task automatic run_cal(input int sel, input bit src, input int win, output int unsigned r);
    wr_reg(3'd2, 16'(win));
    wr_reg(3'd0, 16'(sel) | 16'h0004 | (src ? 16'h0008 : 16'h0));
    wait_idle("R3 busy self-clears");
    read_res(r);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 190000 && !done_flag) begin
      done_flag = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unsigned res;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 8; a += 2) begin
      rd_reg(3'(a), v);
      check(v == 16'd0, "R1 reset value", int'(v), 0);
    end

    // R2 control layout
    wr_reg(3'd0, 16'hFFF3);
    rd_reg(3'd0, v);
    check(v == 16'h0003, "R2 ctrl readback", int'(v), 3);
    wr_reg(3'd1, 16'h000A);   // odd offset maps to ctrl as well (R12)
    rd_reg(3'd0, v);
    check(v == 16'h000A, "R2 sel/src fields", int'(v), 10);
    wr_reg(3'd0, 16'h0000);

    // R4 window readback
    wr_reg(3'd2, 16'hA5C3);
    rd_reg(3'd2, v);
    check(v == 16'hA5C3, "R4 window readback", int'(v), 'hA5C3);

    // R5/R6 each reference
    for (int s = 0; s < 4; s++) begin
      run_cal(s, 1'b0, 3, res);
      check(res == 3 * 2 * half[s], $sformatf("R6 R5 sel=%0d", s), int'(res), 6 * half[s]);
    end

    // R11 large count, R10 writes during busy
    wr_reg(3'd2, 16'd2000);
    wr_reg(3'd0, 16'h0004);
    rd_reg(3'd0, v);
    check(v == 16'h0004, "R3 busy visible", int'(v), 4);
    wr_reg(3'd0, 16'h0009);
    wr_reg(3'd2, 16'd7);
    rd_reg(3'd0, v);
    check(v == 16'h0004, "R10 ctrl write ignored", int'(v), 4);
    rd_reg(3'd2, v);
    check(v == 16'd2000, "R10 window write ignored", int'(v), 2000);
    wait_idle("R3 long run");
    read_res(res);
    check(res == 32'd80000, "R11 result both halves", int'(res), 80000);
    wr_reg(3'd4, 16'hFFFF);
    wr_reg(3'd6, 16'hFFFF);
    read_res(res);
    check(res == 32'd80000, "R11 result write ignored", int'(res), 80000);

    // R8 zero window
    run_cal(1, 1'b0, 0, res);
    check(res == 6, "R8 zero window", int'(res), 6);

    // R7 clear at start
    wr_reg(3'd2, 16'd1);
    wr_reg(3'd0, 16'h0006);
    rd_reg(3'd4, v);
    check(v == 16'd0, "R7 result cleared", int'(v), 0);
    wait_idle("R3 after clear");
    read_res(res);
    check(res == 50, "R5 window of one", int'(res), 50);

    // R9 external gating
    ext_pat = 0;
    run_cal(3, 1'b1, 2, res);
    check(res == 0, "R9 gate low", int'(res), 0);
    ext_pat = 1;
    run_cal(3, 1'b1, 2, res);
    check(res == 44, "R9 gate high", int'(res), 44);
    ext_pat = 2;
    run_cal(0, 1'b1, 5, res);
    check(res > 0 && res < 200, "R9 gate toggling partial", int'(res), 100);

    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule